// File: doc/BRIEF.md
# Line-Tagged Receive Silo

This block is the common receive buffer of a sixteen-line serial multiplexer. Every line's receiver hands over a finished character together with its line number and its parity and framing status. All lines share one first-in first-out store. The host sees a single receive register. Each read of it returns the oldest character and removes it. The top bit of the returned word marks it as valid, so software drains the store by reading until the word is no longer negative.

The host can set an alarm level. When a stored character brings the fill level up to that level, a receive flag is raised, and the flag drives the interrupt line while the receive enable is set. A maintenance mode swaps the external receive inputs for a loop-back input, which lets the transmit side be tested against the store without outside wiring. A master-clear command empties the store and returns the alarm level to zero.

Top module: `rx_silo_top`

## Requirements
- R1: After reset the control register (address 0) and the alarm register (address 2) read 0, the receive register (address 1) reads with bit 15 clear, and `irq` is 0.
- R2: A stored character reads back as bit 15 = 1, bit 14 = overrun, bit 13 = framing error, bit 12 = parity error, bits 11:8 = line number, bits 7:0 = data.
- R3: Each host read of address 1 returns the oldest entry and removes it, in arrival order. A read of an empty store returns bit 15 = 0 and changes nothing.
- R4: The store holds 64 entries. A character offered while the store is full and no read happens in that cycle is discarded. The next character actually stored carries the overrun bit, and later ones do not.
- R5: Control bit 7 (receive flag) is set in any cycle where a character is stored and the resulting fill level is at or above the alarm level (address 2, bits 6:0). A control write with bit 7 = 0 clears the flag. A write with bit 7 = 1 does not set it.
- R6: `irq` is high exactly when the receive flag and control bit 6 (receive enable) are both 1.
- R7: While control bit 9 (maintenance) is 1, the external receive inputs are ignored and loop-back characters are stored with both error bits 0. While it is 0, loop-back characters are ignored.
- R8: A control write with bit 11 = 1 empties the store, sets the alarm level to 0, clears the flag and any pending overrun, and takes bits 9 and 6 from the written value. Bit 11 always reads 0.
- R9: When the store is full, a character offered in the same cycle as a host read is stored, and the fill level stays at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_valid | input | 1 | External receiver offers a character this cycle |
| ext_line | input | 4 | Line number of the external character |
| ext_data | input | 8 | External character data |
| ext_perr | input | 1 | Parity error on the external character |
| ext_ferr | input | 1 | Framing error (break) on the external character |
| lb_valid | input | 1 | Loop-back source offers a character this cycle |
| lb_line | input | 4 | Line number of the loop-back character |
| lb_data | input | 8 | Loop-back character data |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (pops when address is 1) |
| reg_addr | input | 2 | Register select: 0 control, 1 receive, 2 alarm |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data of the selected register, valid in the same cycle |
| irq | output | 1 | Receive interrupt request |

## Verification
On every cycle the assertions check the following. The store never accepts a write while it is full unless a read happens in the same cycle. The fill level never goes past the depth. A read of an empty store leaves the level at zero. A dropped character always leaves an overrun mark pending. Storing a character always clears that mark. The flag rises only in a cycle with a store and falls only on a control write. A master clear leaves the store empty and the alarm level at zero. Only the bench scenarios can show the arrival order, the exact bit layout of each returned word, the alarm threshold at several levels, the interrupt gating, and how the maintenance switch chooses between the two sources.

// File: rtl/rx_silo_pkg.sv
// Shared field positions, register addresses and the stored entry layout
// of the receive silo. The entry packs so that it lines up with the
// 15 low bits of the receive word; bit 15 is added at read time.
package rx_silo_pkg;

    localparam int WORD_W     = 16;
    localparam int LINE_W     = 4;
    localparam int DATA_W     = 8;

    // Receive word fields.
    localparam int RW_VALID   = 15;

    // Control register fields.
    localparam int CT_FLAG    = 7;
    localparam int CT_ENABLE  = 6;
    localparam int CT_MAINT   = 9;
    localparam int CT_MCLR    = 11;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_RXW   = 2'd1,
        ADDR_ALARM = 2'd2,
        ADDR_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [LINE_W-1:0] line;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rx_silo_fifo.sv
// Circular store for tagged receive entries.
// Assumes: the writer never writes while full unless a read is in the same
// cycle; flush has priority over both read and write. Also publishes the
// fill level that will hold after this cycle, for the alarm comparator.
module rx_silo_fifo
    import rx_silo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  rx_entry_t        wr_entry,
    input  logic             rd_en,
    output rx_entry_t        head,
    output logic [CNT_W-1:0] level,
    output logic [CNT_W-1:0] level_next,
    output logic             full,
    output logic             empty
);
    localparam int  PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit  IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

    rx_entry_t          mem [DEPTH];
    logic [PTR_W-1:0]   wp, rp, wp_inc, rp_inc;
    logic               do_wr, do_rd;

    assign full  = (level == CNT_W'(DEPTH));
    assign empty = (level == '0);
    assign do_wr = wr_en && !flush;
    assign do_rd = rd_en && !empty && !flush;
    assign head  = mem[rp];

    // Pointer wrap: free-running for power-of-two depths, compared otherwise.
    generate
        if (IS_POW2) begin : g_wrap_free
            assign wp_inc = wp + 1'b1;
            assign rp_inc = rp + 1'b1;
        end else begin : g_wrap_cmp
            assign wp_inc = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            assign rp_inc = (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
        end
    endgenerate

    // Fill level after this cycle's flush, write and read.
    always_comb begin
        level_next = level;
        if (flush) begin
            level_next = '0;
        end else begin
            case ({do_wr, do_rd})
                2'b10:   level_next = level + 1'b1;
                2'b01:   level_next = level - 1'b1;
                default: level_next = level;
            endcase
        end
    end

    // Entry storage; holds data only, so it carries no reset.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp] <= wr_entry;
        end
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_wr) wp <= wp_inc;
            if (do_rd) rp <= rp_inc;
            level <= level_next;
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |-> rd_en);

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> (level == '0));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/rx_silo_ingress.sv
// Source selection and overrun tagging in front of the store.
// Picks the loop-back or the external receiver according to the maintenance
// mode, drops a character that finds the store full, and marks the next
// stored character with the overrun bit.
module rx_silo_ingress
    import rx_silo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_mode,
    input  logic              flush,
    input  logic              ext_valid,
    input  logic [LINE_W-1:0] ext_line,
    input  logic [DATA_W-1:0] ext_data,
    input  logic              ext_perr,
    input  logic              ext_ferr,
    input  logic              lb_valid,
    input  logic [LINE_W-1:0] lb_line,
    input  logic [DATA_W-1:0] lb_data,
    input  logic              full,
    input  logic              pop,
    output logic              store,
    output rx_entry_t         store_entry
);
    logic req;
    logic drop;
    logic ovr_pend;

    // Source mux: loop-back characters carry no line errors.
    always_comb begin
        if (loop_mode) begin
            req               = lb_valid;
            store_entry.line  = lb_line;
            store_entry.data  = lb_data;
            store_entry.perr  = 1'b0;
            store_entry.ferr  = 1'b0;
        end else begin
            req               = ext_valid;
            store_entry.line  = ext_line;
            store_entry.data  = ext_data;
            store_entry.perr  = ext_perr;
            store_entry.ferr  = ext_ferr;
        end
        store_entry.ovr = ovr_pend;
    end

    assign store = req && (!full || pop);
    assign drop  = req && full && !pop;

    // Pending overrun mark: set by a drop, consumed by the next store.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ovr_pend <= 1'b0;
        end else if (drop) begin
            ovr_pend <= 1'b1;
        end else if (store) begin
            ovr_pend <= 1'b0;
        end
    end

    assert_drop_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !flush) |=> ovr_pend);

    assert_tag_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> !ovr_pend);

    assert_loop_blocks_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_mode && !lb_valid) |-> !store);

endmodule

// File: rtl/rx_silo_regs.sv
// Control and alarm registers of the silo.
// Holds the enable, maintenance and flag bits and the alarm level, and
// decodes the master-clear command. The flag is set by a store that leaves
// the level at or above the alarm, and is cleared only by a control write of 0.
module rx_silo_regs
    import rx_silo_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              alarm_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              store,
    input  logic [CNT_W-1:0]  level_next,
    output logic              flag,
    output logic              enable,
    output logic              loop_mode,
    output logic              mclr,
    output logic [CNT_W-1:0]  alarm,
    output logic              irq
);
    logic flag_set;

    assign mclr     = ctrl_wr && wdata[CT_MCLR];
    assign flag_set = store && (level_next >= alarm);
    assign irq      = flag && enable;

    // Mode bits follow any control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable    <= 1'b0;
            loop_mode <= 1'b0;
        end else if (ctrl_wr) begin
            enable    <= wdata[CT_ENABLE];
            loop_mode <= wdata[CT_MAINT];
        end
    end

    // Alarm level: written directly, zeroed by master clear.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            alarm <= '0;
        end else if (alarm_wr) begin
            alarm <= wdata[CNT_W-1:0];
        end
    end

    // Receive flag: master clear first, then a threshold hit, then a write of 0.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            flag <= 1'b0;
        end else if (flag_set) begin
            flag <= 1'b1;
        end else if (ctrl_wr && !wdata[CT_FLAG]) begin
            flag <= 1'b0;
        end
    end

    assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(store));

    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ctrl_wr) |=> flag);

endmodule

// File: rtl/rx_silo_top.sv
// Line-tagged receive silo: the shared receive store of a sixteen-line
// multiplexer with its host register view.
// Assumes: one host access per cycle; read data is valid in the same cycle
// as the read strobe, and a read of the receive register pops on that edge.
module rx_silo_top
    import rx_silo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_valid,
    input  logic [3:0]        ext_line,
    input  logic [7:0]        ext_data,
    input  logic              ext_perr,
    input  logic              ext_ferr,
    input  logic              lb_valid,
    input  logic [3:0]        lb_line,
    input  logic [7:0]        lb_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    reg_sel_e          sel;
    rx_entry_t         head, store_entry;
    logic [CNT_W-1:0]  level, level_next, alarm;
    logic              full, empty, store, pop_req, pop;
    logic              flag, enable, loop_mode, mclr;
    logic              ctrl_wr, alarm_wr;

    assign sel      = reg_sel_e'(reg_addr);
    assign ctrl_wr  = reg_wr && (sel == ADDR_CTRL);
    assign alarm_wr = reg_wr && (sel == ADDR_ALARM);
    assign pop_req  = reg_rd && (sel == ADDR_RXW);
    assign pop      = pop_req && !empty;

    rx_silo_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .alarm_wr   (alarm_wr),
        .wdata      (reg_wdata),
        .store      (store),
        .level_next (level_next),
        .flag       (flag),
        .enable     (enable),
        .loop_mode  (loop_mode),
        .mclr       (mclr),
        .alarm      (alarm),
        .irq        (irq)
    );

    rx_silo_ingress u_ingress (
        .clk         (clk),
        .rst_n       (rst_n),
        .loop_mode   (loop_mode),
        .flush       (mclr),
        .ext_valid   (ext_valid),
        .ext_line    (ext_line),
        .ext_data    (ext_data),
        .ext_perr    (ext_perr),
        .ext_ferr    (ext_ferr),
        .lb_valid    (lb_valid),
        .lb_line     (lb_line),
        .lb_data     (lb_data),
        .full        (full),
        .pop         (pop),
        .store       (store),
        .store_entry (store_entry)
    );

    rx_silo_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (mclr),
        .wr_en      (store),
        .wr_entry   (store_entry),
        .rd_en      (pop_req),
        .head       (head),
        .level      (level),
        .level_next (level_next),
        .full       (full),
        .empty      (empty)
    );

    // Host read mux; the receive word gets its valid bit only when non-empty.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            ADDR_CTRL: begin
                reg_rdata[CT_FLAG]   = flag;
                reg_rdata[CT_ENABLE] = enable;
                reg_rdata[CT_MAINT]  = loop_mode;
            end
            ADDR_RXW: begin
                if (!empty) begin
                    reg_rdata = {1'b1, head};
                end
            end
            ADDR_ALARM: reg_rdata = WORD_W'(alarm);
            default:    reg_rdata = '0;
        endcase
    end

    assert_mclr_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (empty && (alarm == '0) && !flag));

    assert_full_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && pop && store && !mclr) |=> full);

endmodule

// File: tb/sim_rx_silo_top.sv
// Bench for the receive silo: sweeps lines and error flags, fills the store
// to its depth, sweeps alarm levels and exercises both input sources.
module sim_rx_silo_top;
    localparam int DEPTH = 64;
    localparam logic [1:0] A_CTRL = 2'd0, A_RXW = 2'd1, A_ALARM = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ext_valid, ext_perr, ext_ferr, lb_valid;
    logic [3:0]  ext_line, lb_line;
    logic [7:0]  ext_data, lb_data;
    logic        reg_wr, reg_rd;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_silo_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ext_valid(ext_valid), .ext_line(ext_line), .ext_data(ext_data),
        .ext_perr(ext_perr), .ext_ferr(ext_ferr),
        .lb_valid(lb_valid), .lb_line(lb_line), .lb_data(lb_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [15:0] word(input logic ov, input logic fe,
                                         input logic pe, input logic [3:0] ln,
                                         input logic [7:0] d);
        return {1'b1, ov, fe, pe, ln, d};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_ext(input logic [3:0] ln, input logic [7:0] d,
                            input logic pe, input logic fe);
        @(negedge clk);
        ext_valid = 1'b1; ext_line = ln; ext_data = d; ext_perr = pe; ext_ferr = fe;
        @(negedge clk);
        ext_valid = 1'b0;
    endtask

    task automatic push_lb(input logic [3:0] ln, input logic [7:0] d);
        @(negedge clk);
        lb_valid = 1'b1; lb_line = ln; lb_data = d;
        @(negedge clk);
        lb_valid = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic fill(input int n);
        for (int k = 0; k < n; k++) push_ext(4'(k), 8'(k), 1'b0, 1'b0);
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int levels [4] = '{1, 5, 16, 64};
        rst_n = 1'b0; ext_valid = 0; ext_perr = 0; ext_ferr = 0; lb_valid = 0;
        ext_line = 0; ext_data = 0; lb_line = 0; lb_data = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        read_reg(A_CTRL, v);  chk("R1 ctrl", v, 16'h0000);
        read_reg(A_ALARM, v); chk("R1 alarm", v, 16'h0000);
        read_reg(A_RXW, v);   chk("R1 rx valid", {15'b0, v[15]}, 16'h0);
        chk("R1 irq", {15'b0, irq}, 16'h0);

        // R2, R3: every line with all error combinations, read back in order
        for (int i = 0; i < 16; i++)
            push_ext(4'(i), 8'(i * 17 + 3), i[0], i[1]);
        for (int i = 0; i < 16; i++) begin
            read_reg(A_RXW, v);
            chk("R2 R3 tagged word", v, word(1'b0, i[1], i[0], 4'(i), 8'(i * 17 + 3)));
        end
        read_reg(A_RXW, v); chk("R3 empty read", {15'b0, v[15]}, 16'h0);
        read_reg(A_RXW, v); chk("R3 second empty read", {15'b0, v[15]}, 16'h0);

        // R4: fill to depth, overflow drops and tags the next stored char
        fill(DEPTH);
        push_ext(4'hF, 8'hEE, 1'b0, 1'b0);
        for (int k = 0; k < DEPTH; k++) begin
            read_reg(A_RXW, v);
            chk("R4 full drain", v, word(1'b0, 1'b0, 1'b0, 4'(k), 8'(k)));
        end
        read_reg(A_RXW, v); chk("R4 dropped char absent", {15'b0, v[15]}, 16'h0);
        push_ext(4'h3, 8'hA1, 1'b0, 1'b0);
        push_ext(4'h4, 8'hA2, 1'b0, 1'b0);
        read_reg(A_RXW, v); chk("R4 overrun tag", v, word(1'b1, 1'b0, 1'b0, 4'h3, 8'hA1));
        read_reg(A_RXW, v); chk("R4 tag once", v, word(1'b0, 1'b0, 1'b0, 4'h4, 8'hA2));

        // R9: push and read in one cycle while full
        fill(DEPTH);
        @(negedge clk);
        ext_valid = 1'b1; ext_line = 4'h9; ext_data = 8'h5A; ext_perr = 0; ext_ferr = 0;
        reg_rd = 1'b1; reg_addr = A_RXW;
        #1 v = reg_rdata;
        @(negedge clk);
        ext_valid = 1'b0; reg_rd = 1'b0;
        chk("R9 head popped", v, word(1'b0, 1'b0, 1'b0, 4'h0, 8'h00));
        for (int k = 1; k < DEPTH; k++) begin
            read_reg(A_RXW, v);
            chk("R9 drain", v, word(1'b0, 1'b0, 1'b0, 4'(k), 8'(k)));
        end
        read_reg(A_RXW, v); chk("R9 stored no overrun", v, word(1'b0, 1'b0, 1'b0, 4'h9, 8'h5A));
        read_reg(A_RXW, v); chk("R9 then empty", {15'b0, v[15]}, 16'h0);

        // R5, R6: alarm level sweep
        foreach (levels[j]) begin
            int lv = levels[j];
            write_reg(A_CTRL, 16'h0800);
            write_reg(A_ALARM, 16'(lv));
            read_reg(A_ALARM, v); chk("R5 alarm readback", v, 16'(lv));
            write_reg(A_CTRL, 16'h0040);
            fill(lv - 1);
            read_reg(A_CTRL, v); chk("R5 below alarm", v, 16'h0040);
            chk("R6 irq low below alarm", {15'b0, irq}, 16'h0);
            push_ext(4'h1, 8'h11, 1'b0, 1'b0);
            read_reg(A_CTRL, v); chk("R5 alarm reached", v, 16'h00C0);
            chk("R6 irq high", {15'b0, irq}, 16'h1);
            write_reg(A_CTRL, 16'h0040);
            read_reg(A_CTRL, v); chk("R5 write zero clears", v, 16'h0040);
            chk("R6 irq after clear", {15'b0, irq}, 16'h0);
            write_reg(A_CTRL, 16'h00C0);
            read_reg(A_CTRL, v); chk("R5 write one no set", v, 16'h0040);
            push_ext(4'h2, 8'h22, 1'b0, 1'b0);
            read_reg(A_CTRL, v);
            if (lv < DEPTH) begin
                chk("R5 store above alarm sets", v, 16'h00C0);
                write_reg(A_CTRL, 16'h0080);
                read_reg(A_CTRL, v); chk("R6 flag kept, enable off", v, 16'h0080);
                chk("R6 irq gated off", {15'b0, irq}, 16'h0);
            end else begin
                chk("R5 R4 dropped char sets nothing", v, 16'h0040);
            end
        end

        // R8: master clear empties, zeroes alarm, drops pending overrun
        write_reg(A_CTRL, 16'h0800);
        fill(DEPTH);
        push_ext(4'h7, 8'h77, 1'b0, 1'b0);
        write_reg(A_ALARM, 16'd9);
        write_reg(A_CTRL, 16'h0840);
        read_reg(A_CTRL, v);  chk("R8 ctrl after clear", v, 16'h0040);
        read_reg(A_ALARM, v); chk("R8 alarm zeroed", v, 16'h0000);
        read_reg(A_RXW, v);   chk("R8 store empty", {15'b0, v[15]}, 16'h0);
        write_reg(A_CTRL, 16'h0000);
        push_ext(4'h6, 8'h66, 1'b1, 1'b0);
        read_reg(A_RXW, v);   chk("R8 overrun cleared", v, word(1'b0, 1'b0, 1'b1, 4'h6, 8'h66));

        // R7: maintenance selects the loop-back source
        write_reg(A_CTRL, 16'h0200);
        read_reg(A_CTRL, v); chk("R7 maint readback", v, 16'h0200);
        push_ext(4'h5, 8'h55, 1'b1, 1'b1);
        read_reg(A_RXW, v);  chk("R7 ext ignored in maint", {15'b0, v[15]}, 16'h0);
        push_lb(4'hC, 8'hC3);
        read_reg(A_RXW, v);  chk("R7 loop-back stored", v, word(1'b0, 1'b0, 1'b0, 4'hC, 8'hC3));
        write_reg(A_CTRL, 16'h0000);
        push_lb(4'hD, 8'hD4);
        read_reg(A_RXW, v);  chk("R7 loop-back ignored", {15'b0, v[15]}, 16'h0);
        push_ext(4'hE, 8'hE5, 1'b0, 1'b1);
        read_reg(A_RXW, v);  chk("R7 ext accepted", v, word(1'b0, 1'b1, 1'b0, 4'hE, 8'hE5));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule